// File: doc/BRIEF.md
# Ethernet Receive Preamble and Start-Delimiter Qualifier

This block sits at the front of an Ethernet receive path. It watches the receive-data-valid line and the receive data pins. It checks the preamble and the start-of-frame delimiter at the start of every frame, strips them, and then packs the symbols that follow into payload bytes. A static mode input selects one of two line formats. In 1-bit serial mode one bit arrives per clock on `rx_d[0]`. In MII mode one 4-bit nibble arrives per clock.

A frame whose header fails any check is dropped. The `hdr_reject` flag goes high and stays high, and no payload is produced until data-valid falls. When data-valid deasserts, the block goes back to idle, whatever state it was in. Downstream logic receives a one-cycle `pay_valid` strobe per byte and a `pay_sop` pulse with the first byte of each frame.

Top module: `eth_sfd_detect`

## Requirements
- R1: In serial mode (`mii_mode`=0) one bit per clock is taken from `rx_d[0]`, least significant bit first, and `rx_d[3:1]` is ignored. Bit times are numbered from 1 at the first clock with `rx_dv` high, and bit times 1 to 16 are never examined.
- R2: In serial mode each of bit times 18 to 21 must differ from the bit before it. A repeated pair (00 or 11) ending anywhere in that window rejects the frame.
- R3: In serial mode, from bit time 22 onward, alternation may continue for any length. The first repeated pair settles the header: 11 ends the delimiter and 00 rejects the frame.
- R4: In MII mode (`mii_mode`=1) one nibble per clock is taken from `rx_d`, low nibble of each byte first. Zero or more bytes of 0x55 may come first. A byte of 0xD5 ends the header, and any other completed header byte rejects the frame.
- R5: In MII mode, two adjacent 0 bits seen before the delimiter completes reject the frame. Bit order is LSB-first, and the pair may sit inside one nibble or span a nibble boundary.
- R6: Preamble and delimiter symbols are never forwarded. Payload bytes are assembled LSB-first from the symbols after the delimiter: 8 bits in serial mode, or a low nibble and then a high nibble in MII mode. `pay_valid` is high for one cycle, in the clock cycle after the byte's final symbol is sampled, with the byte on `pay_byte`.
- R7: `pay_sop` is high together with `pay_valid` for the first payload byte of a frame only.
- R8: `hdr_reject` rises in the cycle after the offending symbol is sampled. It stays high while `rx_dv` stays high, and no payload byte is produced while it is high.
- R9: One clock with `rx_dv` low returns the block to idle. It clears `hdr_reject`, discards any partial byte, and restarts bit-time counting for the next frame.
- R10: After reset, `pay_valid`, `pay_sop` and `hdr_reject` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mii_mode | input | 1 | 0 = serial bit mode, 1 = nibble mode; change only while rx_dv is low |
| rx_dv | input | 1 | Receive data valid |
| rx_d | input | 4 | Receive data (bit 0 only in serial mode) |
| pay_sop | output | 1 | First payload byte of the frame |
| pay_byte | output | 8 | Payload byte, valid with pay_valid |
| pay_valid | output | 1 | One-cycle payload byte strobe |
| hdr_reject | output | 1 | Header rejected; rest of frame dropped |

## Verification
The bench aims at the edges of the serial bit-time window. It puts 00 patterns inside the ignored first 16 bits, repeated pairs at bit times 18 to 21, and the shortest possible delimiter, which resolves at bit 22. An off-by-one window would reject good frames or accept broken ones, and would shift every payload byte by a bit. In nibble mode it drives frames with no preamble, with a foreign header byte, and with a 00 pair that exists only across a nibble boundary. A checker that skips that boundary would accept the frame and emit bytes where none belong. It also drops data-valid partway through a byte and restarts at once. Stale counter state would show up there as a phantom byte or a lingering reject.

// File: rtl/eth_sfd_pkg.sv
`timescale 1ns/1ps
package eth_sfd_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_PAY  = 2'd1,
    ST_DROP = 2'd2
  } rx_st_e;

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;
endpackage

// File: rtl/sfd_serial_chk.sv
`timescale 1ns/1ps
// Serial header qualifier: skip window, alternation window, then resolve.
module sfd_serial_chk #(
  parameter int SKIP_BITS = 16,
  parameter int ALT_BITS  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  input  logic bit_i,
  output logic hdr_done,
  output logic hdr_bad
);
  localparam int LAST = SKIP_BITS + ALT_BITS;
  localparam int CW   = $clog2(LAST + 1);
  localparam logic [CW-1:0] ALT_LO  = CW'(SKIP_BITS + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(LAST);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          prev_q, prev_d;
  logic          same, in_alt, in_res;

  always_comb begin
    same     = (bit_i == prev_q);
    in_alt   = (cnt_q >= ALT_LO) && (cnt_q < CNT_TOP);
    in_res   = (cnt_q == CNT_TOP);
    hdr_bad  = step_i & same & (in_alt | (in_res & ~bit_i));
    hdr_done = step_i & same & in_res & bit_i;
    cnt_d    = cnt_q;
    prev_d   = prev_q;
    if (clr_i) begin
      cnt_d  = '0;
      prev_d = 1'b0;
    end else if (step_i) begin
      prev_d = bit_i;
      if (!in_res) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/sfd_mii_chk.sv
`timescale 1ns/1ps
// Nibble header qualifier: byte match plus zero-pair scan across nibbles.
module sfd_mii_chk #(
  parameter logic [7:0] PRE = 8'h55,
  parameter logic [7:0] SFD = 8'hD5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       step_i,
  input  logic [3:0] nib_i,
  output logic       hdr_done,
  output logic       hdr_bad
);
  logic       hi_q, hi_d;
  logic [3:0] lo_q, lo_d;
  logic       last_q, last_d;
  logic       have_q, have_d;
  logic [3:0] zz;
  logic       pair00;
  logic [7:0] full;

  // zero pair between bit k-1 and bit k of the LSB-first stream
  always_comb begin
    zz[0] = have_q & ~last_q & ~nib_i[0];
    for (int k = 1; k < 4; k++) zz[k] = ~nib_i[k-1] & ~nib_i[k];
  end

  always_comb begin
    pair00   = |zz;
    full     = {nib_i, lo_q};
    hdr_bad  = step_i & (pair00 | (hi_q & (full != PRE) & (full != SFD)));
    hdr_done = step_i & hi_q & ~pair00 & (full == SFD);
    hi_d     = hi_q;
    lo_d     = lo_q;
    last_d   = last_q;
    have_d   = have_q;
    if (clr_i) begin
      hi_d   = 1'b0;
      lo_d   = '0;
      last_d = 1'b0;
      have_d = 1'b0;
    end else if (step_i) begin
      hi_d   = ~hi_q;
      lo_d   = nib_i;
      last_d = nib_i[3];
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      lo_q   <= '0;
      last_q <= 1'b0;
      have_q <= 1'b0;
    end else begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      last_q <= last_d;
      have_q <= have_d;
    end
  end
endmodule

// File: rtl/sfd_byte_pack.sv
`timescale 1ns/1ps
// Payload assembler: LSB-first shift of bits or nibbles into bytes.
module sfd_byte_pack #(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic              mii_i,
  input  logic [NIB_W-1:0]  d_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              vld_o,
  output logic              sop_o
);
  localparam int SER_STEPS = BYTE_W;
  localparam int MII_STEPS = BYTE_W / NIB_W;
  localparam int CNT_W     = $clog2(SER_STEPS);
  localparam logic [CNT_W-1:0] SER_LAST = CNT_W'(SER_STEPS - 1);
  localparam logic [CNT_W-1:0] MII_LAST = CNT_W'(MII_STEPS - 1);

  logic [BYTE_W-1:0] sh_q, sh_d, sh_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              first_q, first_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              vld_q, vld_d, sop_q, sop_d;
  logic              last, emit;

  always_comb begin
    sh_nx   = mii_i ? {d_i, sh_q[BYTE_W-1:NIB_W]} : {d_i[0], sh_q[BYTE_W-1:1]};
    last    = (cnt_q == (mii_i ? MII_LAST : SER_LAST));
    emit    = step_i & last;
    sh_d    = step_i ? sh_nx : sh_q;
    cnt_d   = cnt_q;
    first_d = first_q;
    byte_d  = emit ? sh_nx : byte_q;
    vld_d   = emit;
    sop_d   = emit & first_q;
    if (clr_i) begin
      cnt_d   = '0;
      first_d = 1'b1;
      vld_d   = 1'b0;
      sop_d   = 1'b0;
    end else if (step_i) begin
      cnt_d = last ? '0 : cnt_q + 1'b1;
      if (last) first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      first_q <= 1'b1;
      byte_q  <= '0;
      vld_q   <= 1'b0;
      sop_q   <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
      byte_q  <= byte_d;
      vld_q   <= vld_d;
      sop_q   <= sop_d;
    end
  end

  assign byte_o = byte_q;
  assign vld_o  = vld_q;
  assign sop_o  = sop_q;
endmodule

// File: rtl/eth_sfd_detect.sv
`timescale 1ns/1ps
module eth_sfd_detect #(
  parameter int SKIP_BITS = 16,
  parameter int ALT_BITS  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mii_mode,
  input  logic       rx_dv,
  input  logic [3:0] rx_d,
  output logic       pay_sop,
  output logic [7:0] pay_byte,
  output logic       pay_valid,
  output logic       hdr_reject
);
  import eth_sfd_pkg::*;

  rx_st_e st_q, st_d;
  logic   hunt, clr;
  logic   s_done, s_bad, m_done, m_bad, done, bad;

  assign clr  = ~rx_dv;
  assign hunt = rx_dv & (st_q == ST_HUNT);

  sfd_serial_chk #(.SKIP_BITS(SKIP_BITS), .ALT_BITS(ALT_BITS)) u_ser (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .step_i(hunt & ~mii_mode),
    .bit_i(rx_d[0]), .hdr_done(s_done), .hdr_bad(s_bad)
  );

  sfd_mii_chk #(.PRE(PRE_BYTE), .SFD(SFD_BYTE)) u_mii (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .step_i(hunt & mii_mode),
    .nib_i(rx_d), .hdr_done(m_done), .hdr_bad(m_bad)
  );

  sfd_byte_pack #(.BYTE_W(8), .NIB_W(4)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr_i(clr),
    .step_i(rx_dv & (st_q == ST_PAY)), .mii_i(mii_mode), .d_i(rx_d),
    .byte_o(pay_byte), .vld_o(pay_valid), .sop_o(pay_sop)
  );

  assign done = mii_mode ? m_done : s_done;
  assign bad  = mii_mode ? m_bad  : s_bad;

  always_comb begin
    st_d = st_q;
    if (!rx_dv) begin
      st_d = ST_HUNT;
    end else if (st_q == ST_HUNT) begin
      if (bad)       st_d = ST_DROP;
      else if (done) st_d = ST_PAY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_HUNT;
    else        st_q <= st_d;
  end

  assign hdr_reject = (st_q == ST_DROP);
endmodule

// File: rtl/sfd_chk.sv
`timescale 1ns/1ps
module sfd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_dv,
  input logic       pay_sop,
  input logic       pay_valid,
  input logic       hdr_reject
);
  // R9: a cycle with data-valid low clears the reject flag
  a_r9_reject_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dv |=> !hdr_reject);
  // R9: no byte follows an idle cycle
  a_r9_no_byte_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dv |=> !pay_valid);
  // R7: start pulse only with a byte strobe
  a_r7_sop_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    pay_sop |-> pay_valid);
  // R8: reject holds while data-valid holds
  a_r8_reject_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_reject && rx_dv |=> hdr_reject);
  // R8: no payload while rejected
  a_r8_no_byte_when_reject: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_reject |-> !pay_valid);
  // R6: strobe lasts one cycle; a byte needs at least two symbols
  a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |=> !pay_valid);
endmodule

bind eth_sfd_detect sfd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .pay_sop(pay_sop),
  .pay_valid(pay_valid), .hdr_reject(hdr_reject)
);

// File: tb/sim_eth_sfd_detect.sv
`timescale 1ns/1ps
module sim_eth_sfd_detect;
  logic       clk;
  logic       rst_n;
  logic       mii_mode;
  logic       rx_dv;
  logic [3:0] rx_d;
  logic       pay_sop;
  logic [7:0] pay_byte;
  logic       pay_valid;
  logic       hdr_reject;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit ended = 0;
  int fr[$];

  eth_sfd_detect u0 (
    .clk(clk), .rst_n(rst_n), .mii_mode(mii_mode), .rx_dv(rx_dv), .rx_d(rx_d),
    .pay_sop(pay_sop), .pay_byte(pay_byte), .pay_valid(pay_valid),
    .hdr_reject(hdr_reject)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !ended) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // expected header outcome: index of last header symbol or of offending symbol
  function automatic void scan(input bit mii, input int s[$],
                               output int hend, output int hbad);
    int pos;
    logic [3:0] n;
    logic [7:0] by;
    bit p;
    hend = -1;
    hbad = -1;
    for (int i = 0; i < s.size(); i++) begin
      if (hend < 0 && hbad < 0) begin
        if (!mii) begin
          pos = i + 1;
          if (pos >= 18 && s[i] == s[i-1]) begin
            if (pos <= 21)      hbad = i;
            else if (s[i] == 1) hend = i;
            else                hbad = i;
          end
        end else begin
          n = 4'(s[i]);
          p = (!n[0] && !n[1]) || (!n[1] && !n[2]) || (!n[2] && !n[3]);
          if (i > 0 && ((s[i-1] >> 3) & 1) == 0 && !n[0]) p = 1;
          if (p) hbad = i;
          else if (i % 2 == 1) begin
            by = {n, 4'(s[i-1])};
            if (by == 8'hD5)      hend = i;
            else if (by != 8'h55) hbad = i;
          end
        end
      end
    end
  endfunction

  task automatic idle_chk(input string tag);
    chk(hdr_reject == 1'b0, "R9", {tag, " reject after idle"}, hdr_reject, 0);
    chk(pay_valid == 1'b0, "R9", {tag, " valid after idle"}, pay_valid, 0);
    chk(pay_sop == 1'b0, "R9", {tag, " sop after idle"}, pay_sop, 0);
  endtask

  task automatic run_frame(input bit mii, input string tag);
    int hend, hbad, per;
    logic [7:0] eb;
    bit ev, es, er;
    scan(mii, fr, hend, hbad);
    per = mii ? 2 : 8;
    @(negedge clk);
    mii_mode = mii;
    rx_dv = 1'b0;
    rx_d = 4'($urandom);
    @(negedge clk);
    idle_chk(tag);
    for (int i = 0; i < fr.size(); i++) begin
      rx_dv = 1'b1;
      rx_d = mii ? 4'(fr[i]) : {3'($urandom), 1'(fr[i] & 1)};
      @(negedge clk);
      er = (hbad >= 0) && (i >= hbad);
      ev = (hend >= 0) && (i > hend) && ((i - hend) % per == 0);
      es = ev && ((i - hend) == per);
      chk(hdr_reject == er, "R8", {tag, " reject"}, hdr_reject, er);
      chk(pay_valid == ev, "R6", {tag, " valid"}, pay_valid, ev);
      chk(pay_sop == es, "R7", {tag, " sop"}, pay_sop, es);
      if (ev) begin
        if (mii) eb = {4'(fr[i]), 4'(fr[i-1])};
        else for (int k = 0; k < 8; k++) eb[k] = 1'(fr[i-7+k] & 1);
        chk(pay_byte == eb, "R6", {tag, " byte"}, pay_byte, eb);
      end
    end
    rx_dv = 1'b0;
    @(negedge clk);
    idle_chk(tag);
  endtask

  task automatic ser_byte(input logic [7:0] b);
    for (int k = 0; k < 8; k++) fr.push_back(int'(b[k]));
  endtask
  task automatic mii_byte(input logic [7:0] b);
    fr.push_back(int'(b[3:0]));
    fr.push_back(int'(b[7:4]));
  endtask
  task automatic ser_lead(input bit zeros);
    for (int k = 0; k < 16; k++) fr.push_back(zeros ? 0 : int'($urandom % 2));
  endtask

  task automatic random_frame();
    bit mii;
    int L, npay, extra;
    mii = 1'($urandom);
    fr.delete();
    if (!mii) begin
      ser_lead(0);
      L = 4 + 2 * int'($urandom % 20);
      for (int k = 0; k < L; k++) fr.push_back((k % 2 == 0) ? 1 : 0);
      fr.push_back(1);
      fr.push_back(1);
    end else begin
      L = int'($urandom % 8);
      for (int k = 0; k < L; k++) mii_byte(8'h55);
      mii_byte(8'hD5);
    end
    npay = int'($urandom % 5);
    for (int k = 0; k < npay; k++) begin
      if (mii) mii_byte(8'($urandom));
      else     ser_byte(8'($urandom));
    end
    extra = int'($urandom % (mii ? 2 : 8));
    for (int k = 0; k < extra; k++) fr.push_back(mii ? int'($urandom % 16) : int'($urandom % 2));
    if ($urandom % 3 == 0) begin
      L = int'($urandom % fr.size());
      if (mii) fr[L] = fr[L] ^ (1 + int'($urandom % 15));
      else     fr[L] = fr[L] ^ 1;
    end
    run_frame(mii, "random R1 R4");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    mii_mode = 1'b0;
    rx_dv = 1'b0;
    rx_d = 4'h0;
    repeat (3) @(negedge clk);
    chk(pay_valid == 1'b0, "R10", "reset valid", pay_valid, 0);
    chk(pay_sop == 1'b0, "R10", "reset sop", pay_sop, 0);
    chk(hdr_reject == 1'b0, "R10", "reset reject", hdr_reject, 0);
    rst_n = 1'b1;

    // R1: zeros in the ignored window, standard preamble
    fr.delete(); ser_lead(1);
    for (int k = 0; k < 6; k++) ser_byte(8'h55);
    ser_byte(8'hD5);
    ser_byte(8'hA3); ser_byte(8'h00); ser_byte(8'hFF); ser_byte(8'h5C);
    run_frame(0, "R1 serial good");

    // R3: shortest delimiter, resolved at bit 22
    fr.delete(); ser_lead(0);
    fr.push_back(1); fr.push_back(0); fr.push_back(1); fr.push_back(0);
    fr.push_back(1); fr.push_back(1);
    ser_byte(8'h3C); ser_byte(8'h81);
    run_frame(0, "R3 serial shortest");

    // R2: 00 at bits 18-19
    fr.delete(); ser_lead(0);
    fr.push_back(1); fr.push_back(0); fr.push_back(0);
    ser_byte(8'h55); ser_byte(8'hD5); ser_byte(8'h12);
    run_frame(0, "R2 serial 00 in window");

    // R2: 11 at bits 19-20
    fr.delete(); ser_lead(0);
    fr.push_back(1); fr.push_back(0); fr.push_back(1); fr.push_back(1);
    ser_byte(8'h42); ser_byte(8'h99);
    run_frame(0, "R2 serial 11 in window");

    // R3 R8: 00 after bit 21, then a delimiter-like tail that must be dropped
    fr.delete(); ser_lead(0);
    for (int k = 0; k < 8; k++) fr.push_back((k % 2 == 0) ? 1 : 0);
    fr.push_back(0);
    fr.push_back(1); fr.push_back(1);
    ser_byte(8'hE7); ser_byte(8'h18);
    run_frame(0, "R3 R8 serial late 00");

    // R4: MII without preamble
    fr.delete(); mii_byte(8'hD5);
    mii_byte(8'h0F); mii_byte(8'hF0); mii_byte(8'h5A);
    run_frame(1, "R4 mii no preamble");

    // R4 R6: MII with seven preamble bytes
    fr.delete();
    for (int k = 0; k < 7; k++) mii_byte(8'h55);
    mii_byte(8'hD5);
    mii_byte(8'h01); mii_byte(8'h80); mii_byte(8'hC3);
    run_frame(1, "R4 R6 mii full preamble");

    // R4: foreign header byte
    fr.delete(); mii_byte(8'h55); mii_byte(8'h57); mii_byte(8'hD5); mii_byte(8'h11);
    run_frame(1, "R4 mii bad byte");

    // R5: 00 inside one nibble
    fr.delete(); mii_byte(8'h55); fr.push_back(1); fr.push_back(13);
    mii_byte(8'hD5); mii_byte(8'h22);
    run_frame(1, "R5 mii 00 in nibble");

    // R5: 00 only across the nibble boundary
    fr.delete(); fr.push_back(5); fr.push_back(10);
    mii_byte(8'hD5); mii_byte(8'h33);
    run_frame(1, "R5 mii 00 across nibbles");

    // R9: drop mid-byte, then a new frame straight after
    fr.delete(); ser_lead(0);
    for (int k = 0; k < 6; k++) fr.push_back((k % 2 == 0) ? 1 : 0);
    fr.push_back(1); fr.push_back(1);
    ser_byte(8'h6B);
    fr.push_back(1); fr.push_back(0); fr.push_back(1);
    run_frame(0, "R9 serial partial");
    fr.delete(); mii_byte(8'h55); mii_byte(8'hD5); mii_byte(8'h77); fr.push_back(9);
    run_frame(1, "R9 mii partial");

    for (int f = 0; f < 300; f++) random_frame();

    finish_run();
  end
endmodule